// File: doc/BRIEF.md
# Ring Event Notification Controller

This block gathers completion and overflow events from a parameterised number of ring channels and signals them to software through a single interrupt line. Each channel has three event flags: transmit finished, receive finished, and receive overflow. The flags are packed without gaps into a bank of 32-bit status words. Reading a status word returns its flags and clears them. A second bank holds a receive enable and a transmit enable for each channel. A read-only capability word reports how many channels the instance was built with.

The interrupt is controlled by a two-state machine. In `ST_ARMED`, the interrupt output is high while any status flag is set together with its enable. A receive overflow flag uses the receive enable of its channel. In the cycle the output is high, the machine takes the transition *fire* into `ST_WAIT_READS` and clears its record of words read. In `ST_WAIT_READS`, every status-word read sets that word's bit in the record. The machine takes the transition *rearm* back to `ST_ARMED` once every status word has been read at least once. This includes words that hold only flags of disabled channels. If enabled flags are still set at that point, the next fire follows.

Software reaches the block through a word-addressed read/write request port. The read response appears one cycle after the request.

Top module: `ring_notify_ctrl`

## Requirements
- R1: A read request is answered in the next cycle with `rsp_valid` high and the data on `rsp_rdata`. `rsp_valid` is low in every other cycle. Reading word address 63 returns the channel count N in bits 10:0 and zero in bits 31:11. Reads of unmapped addresses return 0.
- R2: There are (31+3N)/32 status words at word addresses 0 upward. Flag k of the packed status vector is bit k%32 of word k/32. For channel c, the transmit-finished flag is k=c, the receive-finished flag is k=N+c, and the receive-overflow flag is k=2N+c.
- R3: A status-word read returns the value the word held before the read and clears that word. An event that arrives in the same cycle as a read of its word is still set afterwards.
- R4: There are (31+2N)/32 enable words at word addresses 16 upward. Enable bit c is the receive enable of channel c, and bit N+c is the transmit enable of channel c. Enable bits at 2N and above always read 0. Writes to status words or to the capability word are ignored.
- R5: In `ST_ARMED`, `irq` is high exactly when some transmit-finished flag is set with its transmit enable, or some receive-finished or overflow flag is set with its channel's receive enable. `irq` is never high for two cycles in a row.
- R6: After `irq` fires, it stays low until every status word has been read at least once. This includes words that cover only disabled channels. The block re-arms in the cycle after the last missing read.
- R7: After reset, all status flags and enables are 0, the block is in `ST_ARMED`, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_tx_done | input | NUM_CH | Per-channel transmit-finished event pulses |
| evt_rx_done | input | NUM_CH | Per-channel receive-finished event pulses |
| evt_rx_ovf | input | NUM_CH | Per-channel receive-overflow event pulses |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, one-cycle pulse per fire |

## Verification
A read record that wrongly shows a word as read makes `irq` come back before software has drained the whole bank. A record that wrongly shows a word as unread keeps `irq` silent indefinitely. The behavioural model flags either case on the first cycle where `irq` differs. A status flag that is wrongly cleared, or wrongly left set, shows up in the `rsp_rdata` of the next read of that word. It can show up even earlier as a missing or extra `irq` cycle. A wrong enable mapping shows up as an interrupt that fires or stays silent in the cycle after the event reaches the status bank.

// File: rtl/ring_notify_pkg.sv
package ring_notify_pkg;

    typedef enum logic {
        ST_ARMED      = 1'b0,
        ST_WAIT_READS = 1'b1
    } arm_state_e;

    // Number of 32-bit words needed to hold a packed flag vector
    function automatic int words_for(input int bits);
        return (31 + bits) / 32;
    endfunction

    // Index width for a bank of n words (at least one bit)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ring_notify_status.sv
module ring_notify_status
    import ring_notify_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int NSW    = words_for(3 * NUM_CH),
    parameter int IDX_W  = idx_width(NSW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_tx,
    input  logic [NUM_CH-1:0] evt_rx,
    input  logic [NUM_CH-1:0] evt_ovf,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_word,
    output logic [NUM_CH-1:0] tx_flags,
    output logic [NUM_CH-1:0] rx_flags,
    output logic [NUM_CH-1:0] ovf_flags
);
    localparam int FLAT_W = NSW * 32;

    logic [FLAT_W-1:0] evt_flat;
    logic [FLAT_W-1:0] sts_flat;
    logic [31:0]       sts_q [NSW];

    // Pack the three fields back to back; padding stays zero
    always_comb begin
        evt_flat = '0;
        evt_flat[3*NUM_CH-1:0] = {evt_ovf, evt_rx, evt_tx};
    end

    for (genvar w = 0; w < NSW; w++) begin : g_word
        logic hit;
        assign hit = rd_en && (rd_idx == IDX_W'(w));

        // Clear on read, but a same-cycle event wins
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts_q[w] <= '0;
            end else begin
                sts_q[w] <= (hit ? 32'd0 : sts_q[w]) | evt_flat[w*32 +: 32];
            end
        end

        assign sts_flat[w*32 +: 32] = sts_q[w];
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NSW; w++) begin
            if (rd_idx == IDX_W'(w)) rd_word = sts_q[w];
        end
    end

    assign tx_flags  = sts_flat[NUM_CH-1:0];
    assign rx_flags  = sts_flat[2*NUM_CH-1:NUM_CH];
    assign ovf_flags = sts_flat[3*NUM_CH-1:2*NUM_CH];

endmodule

// File: rtl/ring_notify_enable.sv
module ring_notify_enable
    import ring_notify_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int NEW    = words_for(2 * NUM_CH),
    parameter int IDX_W  = idx_width(NEW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_word,
    output logic [NUM_CH-1:0] rx_en,
    output logic [NUM_CH-1:0] tx_en
);
    localparam int FLAT_W = NEW * 32;
    localparam logic [FLAT_W-1:0] ONE_F = 1;
    localparam logic [FLAT_W-1:0] VALID = (ONE_F << (2 * NUM_CH)) - ONE_F;

    logic [31:0]       en_q [NEW];
    logic [FLAT_W-1:0] en_flat;

    for (genvar w = 0; w < NEW; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[w] <= '0;
            end else if (wr_en && (idx == IDX_W'(w))) begin
                en_q[w] <= wdata & VALID[w*32 +: 32];
            end
        end
        assign en_flat[w*32 +: 32] = en_q[w];
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NEW; w++) begin
            if (idx == IDX_W'(w)) rd_word = en_q[w];
        end
    end

    assign rx_en = en_flat[NUM_CH-1:0];
    assign tx_en = en_flat[2*NUM_CH-1:NUM_CH];

endmodule

// File: rtl/ring_notify_arm_fsm.sv
module ring_notify_arm_fsm
    import ring_notify_pkg::*;
#(
    parameter int NSW   = 2,
    parameter int IDX_W = idx_width(NSW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             irq
);
    localparam logic [NSW-1:0] ONE_M = 1;

    arm_state_e     state_q, state_d;
    logic [NSW-1:0] seen_q, seen_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            seen_q  <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    // Transitions: fire (ARMED -> WAIT_READS), rearm (WAIT_READS -> ARMED)
    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            ST_ARMED: begin
                if (pending) begin
                    state_d = ST_WAIT_READS;
                    seen_d  = '0;
                end
            end
            ST_WAIT_READS: begin
                if (rd_en) seen_d = seen_q | (ONE_M << rd_idx);
                if (&seen_d) state_d = ST_ARMED;
            end
        endcase
    end

    // Outputs
    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            ST_ARMED:      irq = pending;
            ST_WAIT_READS: irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/ring_notify_ctrl.sv
module ring_notify_ctrl
    import ring_notify_pkg::*;
#(
    parameter int NUM_CH   = 12,
    parameter int ADDR_W   = 6,
    parameter int EN_BASE  = 16,
    parameter int CAP_ADDR = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_tx_done,
    input  logic [NUM_CH-1:0] evt_rx_done,
    input  logic [NUM_CH-1:0] evt_rx_ovf,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);
    localparam int NSW    = words_for(3 * NUM_CH);
    localparam int NEW    = words_for(2 * NUM_CH);
    localparam int SIDX_W = idx_width(NSW);
    localparam int EIDX_W = idx_width(NEW);
    localparam logic [ADDR_W-1:0] A_STS_END = ADDR_W'(NSW);
    localparam logic [ADDR_W-1:0] A_EN      = ADDR_W'(EN_BASE);
    localparam logic [ADDR_W-1:0] A_EN_END  = ADDR_W'(EN_BASE + NEW);
    localparam logic [ADDR_W-1:0] A_CAP     = ADDR_W'(CAP_ADDR);

    logic              rd_req, wr_req;
    logic              sts_sel, en_sel, cap_sel;
    logic [SIDX_W-1:0] sts_idx;
    logic [EIDX_W-1:0] en_idx;
    logic [ADDR_W-1:0] en_off;
    logic [31:0]       sts_word, en_word, rdata_d;
    logic [NUM_CH-1:0] tx_sts, rx_sts, ovf_sts, rx_en, tx_en;
    logic              pending;

    assign rd_req  = req_valid && !req_write;
    assign wr_req  = req_valid && req_write;
    assign sts_sel = req_addr < A_STS_END;
    assign en_sel  = (req_addr >= A_EN) && (req_addr < A_EN_END);
    assign cap_sel = req_addr == A_CAP;
    assign sts_idx = SIDX_W'(req_addr);
    assign en_off  = req_addr - A_EN;
    assign en_idx  = EIDX_W'(en_off);

    ring_notify_status #(.NUM_CH(NUM_CH), .NSW(NSW), .IDX_W(SIDX_W)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_tx    (evt_tx_done),
        .evt_rx    (evt_rx_done),
        .evt_ovf   (evt_rx_ovf),
        .rd_en     (rd_req && sts_sel),
        .rd_idx    (sts_idx),
        .rd_word   (sts_word),
        .tx_flags  (tx_sts),
        .rx_flags  (rx_sts),
        .ovf_flags (ovf_sts)
    );

    ring_notify_enable #(.NUM_CH(NUM_CH), .NEW(NEW), .IDX_W(EIDX_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_req && en_sel),
        .idx     (en_idx),
        .wdata   (req_wdata),
        .rd_word (en_word),
        .rx_en   (rx_en),
        .tx_en   (tx_en)
    );

    assign pending = |(tx_sts & tx_en) | |(rx_sts & rx_en) | |(ovf_sts & rx_en);

    ring_notify_arm_fsm #(.NSW(NSW), .IDX_W(SIDX_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .rd_en   (rd_req && sts_sel),
        .rd_idx  (sts_idx),
        .irq     (irq)
    );

    always_comb begin
        rdata_d = '0;
        if (sts_sel)      rdata_d = sts_word;
        else if (en_sel)  rdata_d = en_word;
        else if (cap_sel) rdata_d = {21'd0, 11'(NUM_CH)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rdata_d : 32'd0;
        end
    end

endmodule

// File: rtl/ring_notify_chk.sv
module ring_notify_chk #(
    parameter int NUM_CH   = 12,
    parameter int ADDR_W   = 6,
    parameter int CAP_ADDR = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NUM_CH-1:0] evt_tx_done,
    input logic [NUM_CH-1:0] tx_sts,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              irq
);
    // R5: a fire is a single-cycle pulse
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R1: capability word returns the channel count
    p_cap_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(CAP_ADDR))
        |=> (rsp_valid && rsp_rdata == 32'(NUM_CH)));

    // R1: no response without a read request
    p_rsp_only_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R3: an arriving event is always held, even during a read of its word
    p_event_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_done[0] |=> tx_sts[0]);

    // R3: reading word 0 with no new event clears transmit flag 0
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0 && !evt_tx_done[0])
        |=> !tx_sts[0]);
endmodule

bind ring_notify_ctrl ring_notify_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CAP_ADDR(CAP_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .evt_tx_done (evt_tx_done),
    .tx_sts      (tx_sts),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .irq         (irq)
);

// File: tb/ring_notify_ctrl_tb_top.sv
module ring_notify_ctrl_tb_top;
    localparam int N   = 12;
    localparam int AW  = 6;
    localparam int SW  = (31 + 3 * N) / 32;
    localparam int EW  = (31 + 2 * N) / 32;
    localparam int ENB = 16;
    localparam int CAP = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_tx = '0, ev_rx = '0, ev_ovf = '0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, irq;
    logic [31:0]   rsp_rdata;

    int total = 0, bad = 0, irq_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ring_notify_ctrl #(.NUM_CH(N), .ADDR_W(AW), .EN_BASE(ENB), .CAP_ADDR(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_tx_done(ev_tx), .evt_rx_done(ev_rx), .evt_rx_ovf(ev_ovf),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_sts [SW*32];
    bit          m_en  [EW*32];
    bit          m_seen [SW];
    bit          m_armed;
    bit          m_rv;
    logic [31:0] m_rd;
    bit          m_pend_old, m_all;
    int          m_a;

    function automatic bit m_pending();
        for (int c = 0; c < N; c++) begin
            if (m_sts[c] && m_en[N+c]) return 1'b1;
            if (m_sts[N+c] && m_en[c]) return 1'b1;
            if (m_sts[2*N+c] && m_en[c]) return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_sts[i]) m_sts[i] = 1'b0;
            foreach (m_en[i]) m_en[i] = 1'b0;
            foreach (m_seen[i]) m_seen[i] = 1'b0;
            m_armed = 1'b1; m_rv = 1'b0; m_rd = '0;
        end else begin
            m_a  = int'(req_addr);
            m_rv = req_valid && !req_write;
            m_rd = '0;
            if (m_rv) begin
                if (m_a < SW) for (int b = 0; b < 32; b++) m_rd[b] = m_sts[m_a*32+b];
                else if (m_a >= ENB && m_a < ENB + EW)
                    for (int b = 0; b < 32; b++) m_rd[b] = m_en[(m_a-ENB)*32+b];
                else if (m_a == CAP) m_rd = N;
            end
            m_pend_old = m_pending();
            if (m_armed) begin
                if (m_pend_old) begin
                    m_armed = 1'b0;
                    foreach (m_seen[i]) m_seen[i] = 1'b0;
                end
            end else if (m_rv && m_a < SW) begin
                m_seen[m_a] = 1'b1;
                m_all = 1'b1;
                foreach (m_seen[i]) if (!m_seen[i]) m_all = 1'b0;
                if (m_all) m_armed = 1'b1;
            end
            if (m_rv && m_a < SW) for (int b = 0; b < 32; b++) m_sts[m_a*32+b] = 1'b0;
            for (int c = 0; c < N; c++) begin
                if (ev_tx[c])  m_sts[c] = 1'b1;
                if (ev_rx[c])  m_sts[N+c] = 1'b1;
                if (ev_ovf[c]) m_sts[2*N+c] = 1'b1;
            end
            if (req_valid && req_write && m_a >= ENB && m_a < ENB + EW)
                for (int b = 0; b < 32; b++)
                    if ((m_a-ENB)*32 + b < 2*N) m_en[(m_a-ENB)*32+b] = req_wdata[b];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 irq vs model", {31'd0, irq}, {31'd0, m_armed && m_pending()});
            chk("R1 rsp_valid vs model", {31'd0, rsp_valid}, {31'd0, m_rv});
            if (m_rv) chk("R1 rsp_rdata vs model", rsp_rdata, m_rd);
            if (irq) irq_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        data = rsp_rdata;
    endtask

    task automatic do_write(input int addr, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(addr); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] t, input logic [N-1:0] r, input logic [N-1:0] o);
        @(negedge clk);
        ev_tx = t; ev_rx = r; ev_ovf = o;
        @(negedge clk);
        ev_tx = '0; ev_rx = '0; ev_ovf = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(negedge clk);
        chk("R7 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        chk("R7 irq after reset", {31'd0, irq}, 32'd0);

        do_read(CAP, d);      chk("R1 capability", d, 32'd12);
        do_read(0, d);        chk("R7 status word0 reset", d, 32'd0);
        do_read(ENB, d);      chk("R7 enable reset", d, 32'd0);
        do_read(40, d);       chk("R1 unmapped read", d, 32'd0);

        do_write(ENB, 32'hFFFF_FFFF);
        do_read(ENB, d);      chk("R4 enable padding bits", d, 32'h00FF_FFFF);
        do_write(0, 32'h0000_FFFF);
        do_read(0, d);        chk("R4 status write ignored", d, 32'd0);
        do_write(CAP, 32'h0);
        do_read(CAP, d);      chk("R4 capability write ignored", d, 32'd12);

        // tx done ch3 -> word0 bit3
        base = irq_cnt;
        pulse(12'h008, '0, '0);
        idle(2);
        chk("R5 fire on tx ch3", 32'(irq_cnt - base), 32'd1);
        do_read(0, d);        chk("R2 R3 tx ch3 at word0 bit3", d, 32'h0000_0008);
        do_read(0, d);        chk("R3 cleared after read", d, 32'd0);
        do_read(1, d);        chk("R6 drain word1", d, 32'd0);

        // overflow ch9 with receive enables off -> no fire, word1 bit1
        do_write(ENB, 32'h00FF_F000);
        base = irq_cnt;
        pulse('0, '0, 12'h200);
        idle(3);
        chk("R5 overflow ignored when rx enable off", 32'(irq_cnt - base), 32'd0);
        do_read(1, d);        chk("R2 overflow ch9 at word1 bit1", d, 32'h0000_0002);

        // re-arm needs every word, including the disabled-only one
        do_write(ENB, 32'h00FF_F0FF);
        base = irq_cnt;
        pulse('0, 12'h004, '0);
        idle(2);
        chk("R5 fire on rx ch2", 32'(irq_cnt - base), 32'd1);
        pulse(12'h001, '0, '0);
        idle(2);
        chk("R6 no fire while waiting", 32'(irq_cnt - base), 32'd1);
        do_read(0, d);        chk("R2 rx ch2 and tx ch0 in word0", d, 32'h0000_4001);
        pulse(12'h010, '0, '0);
        idle(2);
        chk("R6 still silent before word1 read", 32'(irq_cnt - base), 32'd1);
        do_read(1, d);        chk("R6 disabled-only word1", d, 32'd0);
        idle(2);
        chk("R6 re-armed fires on held flag", 32'(irq_cnt - base), 32'd2);

        // event in the same cycle as a read of its word
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = '0; ev_tx = 12'h002;
        @(negedge clk);
        req_valid = 1'b0; ev_tx = '0;
        chk("R3 read returns pre-read value", rsp_rdata, 32'h0000_0010);
        do_read(0, d);        chk("R3 same-cycle event kept", d, 32'h0000_0002);
        do_read(1, d);
        idle(2);

        // overflow of rx-enabled ch3 -> word0 bit 27
        base = irq_cnt;
        pulse('0, '0, 12'h008);
        idle(2);
        chk("R5 overflow uses rx enable", 32'(irq_cnt - base), 32'd1);
        do_read(0, d);        chk("R2 overflow ch3 at word0 bit27", d, 32'h0800_0000);
        do_read(1, d);
        idle(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule